// File: doc/BRIEF.md
# Vector Pattern Sequencer

This block runs a stored test program out of an on-chip pattern memory and hands one vector per period to the pin formatters. Each memory word carries a vector value, a timing-set index and a sequencing opcode with an operand. The opcodes pick the active timing set and steer the flow through the program. They cover counted and endless loops over a block of words, jumps taken when captured device data agrees with a parallel or a serial reference pattern, a stall that waits for a software trigger, and a stop.

The host loads the program through a single write port while the sequencer is idle. It can later overwrite just the vector field of any word while a program is running, with no reload. A one-cycle start pulse launches the program from address 0. The loop state lives in a small stack of return address and remaining count pairs, four levels deep by default.

Top module: `vec_seq`

## Requirements
- R1: A memory word is 21 bits with default parameters: vector in bits 7:0, timing-set field in bits 9:8, operand in bits 17:10, opcode in bits 20:18. Opcode values: 0 no-op, 1 set timing set, 2 loop open, 3 loop close, 4 parallel-match jump, 5 serial-match jump, 6 trigger wait, 7 stop.
- R2: A start pulse sampled while idle or stopped begins execution at address 0 with timing set 0, an empty loop stack and the error flag cleared. Word 0 executes on the next clock edge, so its vector is visible two cycles after the start pulse. A start pulse while running or waiting has no effect.
- R3: Every executed word except stop, and except a loop open that overflows, puts its vector on `vecOut` with `vecValid` high in the cycle after it executes. A no-op then advances to the next address, wrapping at the end of memory.
- R4: The set-timing-set opcode makes the word's timing-set field the active timing set. That set applies to its own vector and to every later vector until the next such opcode. Other opcodes ignore the field.
- R5: Loop open with operand n ≥ 1 runs the block between it and the matching loop close n times. Loop close returns to the word after the loop open until the count is used up.
- R6: Loop open with operand 0 repeats its block with no limit. A loop close with no open loop behaves as a no-op.
- R7: Loops nest up to 4 deep. A fifth loop open issues no vector, sets `overflowErr` and stops the sequence (`halted` high). The flag stays set until the next start.
- R8: The parallel jump is taken when `((capData ^ parPat) & parMask) == 0` in the cycle it executes. It then continues at the address in the low 5 operand bits and discards the innermost open loop, if any. Otherwise it falls through.
- R9: A shift register holds the last 8 serial bits, newest in bit 0, and shifts only in cycles with `capValid` high. The serial jump is taken when `((shift ^ serPat) & serMask) == 0`, with the same target and loop handling as R8.
- R10: The trigger-wait opcode issues its vector and then raises `waiting`. It holds that vector valid and unchanged until `swTrig` is seen in a waiting cycle. The next word executes on the following edge.
- R11: The stop opcode issues no vector, drops `vecValid` and raises `halted`.
- R12: A host write with `hostVecOnly` high changes only the vector field of the addressed word. With it low, the whole word is replaced. Writes are accepted while running and take effect at the next execution of that word.
- R13: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the program from address 0 |
| swTrig | input | 1 | Software trigger that releases a trigger wait |
| hostWe | input | 1 | Host write strobe |
| hostVecOnly | input | 1 | Restrict the host write to the vector field |
| hostAddr | input | 5 | Host write address |
| hostData | input | 21 | Host write word |
| capData | input | 8 | Captured parallel device data |
| capBit | input | 1 | Captured serial bit |
| capValid | input | 1 | Shift `capBit` into the serial register |
| parPat | input | 8 | Parallel reference pattern |
| parMask | input | 8 | Parallel compare mask (1 = compared) |
| serPat | input | 8 | Serial reference pattern |
| serMask | input | 8 | Serial compare mask (1 = compared) |
| vecOut | output | 8 | Issued vector |
| tsetOut | output | 2 | Timing set of the issued vector |
| vecValid | output | 1 | A vector is being presented |
| waiting | output | 1 | Stalled on a trigger wait |
| halted | output | 1 | Program stopped |
| overflowErr | output | 1 | Loop stack overflowed |

## Verification
The hardest case to reach is an endless loop left by a taken jump while a live vector patch lands in the loop body. Two things must both hold there: the discarded loop level must not come back at the later loop close, and the patched value must appear without the opcode changing. The stimulus starts the endless loop with the parallel compare failing, patches the body word, then fires a start pulse that must be ignored. Only after that does it present data that matches under the mask with differing masked-off bits. The stray loop close after the jump target then has to behave as a no-op and reach the stop.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_TSET = 3'd1,
    OP_LOOP = 3'd2,
    OP_ENDL = 3'd3,
    OP_JPAR = 3'd4,
    OP_JSER = 3'd5,
    OP_WAIT = 3'd6,
    OP_HALT = 3'd7
  } seqOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;  // present the current word's vector
    logic stop;   // withdraw the vector
  } seqStrobe_t;

endpackage

// File: rtl/vec_seq_lstack.sv
module vec_seq_lstack #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic              dec,
  input  logic [ADDR_W-1:0] pushStart,
  input  logic [CNT_W-1:0]  pushCnt,
  output logic [ADDR_W-1:0] topStart,
  output logic [CNT_W-1:0]  topCnt,
  output logic              empty,
  output logic              full
);

  localparam int DPT_W = $clog2(DEPTH + 1);

  logic [DPT_W-1:0]  depth;
  logic [ADDR_W-1:0] startArr [DEPTH];
  logic [CNT_W-1:0]  cntArr   [DEPTH];

  assign empty = (depth == '0);
  assign full  = (depth == DPT_W'(DEPTH));

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [ADDR_W-1:0] startReg;
      logic [CNT_W-1:0]  cntReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startReg <= '0;
          cntReg   <= '0;
        end else if (push && !full && depth == DPT_W'(i)) begin
          startReg <= pushStart;
          cntReg   <= pushCnt;
        end else if (dec && depth == DPT_W'(i + 1)) begin
          cntReg <= cntReg - 1'b1;
        end
      end

      assign startArr[i] = startReg;
      assign cntArr[i]   = cntReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (clear) begin
      depth <= '0;
    end else if (push && !full) begin
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end

  always_comb begin
    topStart = '0;
    topCnt   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == DPT_W'(i + 1)) begin
        topStart = startArr[i];
        topCnt   = cntArr[i];
      end
    end
  end

endmodule

// File: rtl/vec_seq_dp.sv
module vec_seq_dp
  import vec_seq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int TSET_W = 2,
  parameter int OPND_W = 8,
  parameter int ADDR_W = 5,
  parameter int SER_W  = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [ADDR_W-1:0]                   pc,
  input  seqStrobe_t                          stb,
  input  logic [TSET_W-1:0]                   tsetIn,
  input  logic                                hostWe,
  input  logic                                hostVecOnly,
  input  logic [ADDR_W-1:0]                   hostAddr,
  input  logic [OP_W+OPND_W+TSET_W+VEC_W-1:0] hostData,
  input  logic [VEC_W-1:0]                    capData,
  input  logic                                capBit,
  input  logic                                capValid,
  input  logic [VEC_W-1:0]                    parPat,
  input  logic [VEC_W-1:0]                    parMask,
  input  logic [SER_W-1:0]                    serPat,
  input  logic [SER_W-1:0]                    serMask,
  output logic [OP_W-1:0]                     curOp,
  output logic [OPND_W-1:0]                   curOpnd,
  output logic [TSET_W-1:0]                   curTset,
  output logic                                parHit,
  output logic                                serHit,
  output logic [VEC_W-1:0]                    vecOut,
  output logic [TSET_W-1:0]                   tsetOut,
  output logic                                vecValid
);

  localparam int TSET_LSB = VEC_W;
  localparam int OPND_LSB = TSET_LSB + TSET_W;
  localparam int OP_LSB   = OPND_LSB + OPND_W;
  localparam int WORD_W   = OP_LSB + OP_W;
  localparam int MEM_D    = 1 << ADDR_W;

  logic [WORD_W-1:0] patMem [MEM_D];
  logic [WORD_W-1:0] curWord;
  logic [SER_W-1:0]  serShift;

  // host port: full load or live vector patch
  always_ff @(posedge clk) begin
    if (hostWe) begin
      if (hostVecOnly) begin
        patMem[hostAddr][VEC_W-1:0] <= hostData[VEC_W-1:0];
      end else begin
        patMem[hostAddr] <= hostData;
      end
    end
  end

  assign curWord = patMem[pc];
  assign curOp   = curWord[OP_LSB +: OP_W];
  assign curOpnd = curWord[OPND_LSB +: OPND_W];
  assign curTset = curWord[TSET_LSB +: TSET_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serShift <= '0;
    end else if (capValid) begin
      serShift <= {serShift[SER_W-2:0], capBit};
    end
  end

  assign parHit = (((capData ^ parPat) & parMask) == '0);
  assign serHit = (((serShift ^ serPat) & serMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecOut   <= '0;
      tsetOut  <= '0;
      vecValid <= 1'b0;
    end else if (stb.issue) begin
      vecOut   <= curWord[VEC_W-1:0];
      tsetOut  <= tsetIn;
      vecValid <= 1'b1;
    end else if (stb.stop) begin
      vecValid <= 1'b0;
    end
  end

endmodule

// File: rtl/vec_seq_ctrl.sv
module vec_seq_ctrl
  import vec_seq_pkg::*;
#(
  parameter int TSET_W     = 2,
  parameter int OPND_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int LOOP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              swTrig,
  input  logic [OP_W-1:0]   curOp,
  input  logic [OPND_W-1:0] curOpnd,
  input  logic [TSET_W-1:0] curTset,
  input  logic              parHit,
  input  logic              serHit,
  output logic [ADDR_W-1:0] pc,
  output seqStrobe_t        stb,
  output logic [TSET_W-1:0] tsetNext,
  output logic              waiting,
  output logic              halted,
  output logic              overflowErr
);

  seqState_e         state, stateN;
  seqOp_e            opc;
  logic [ADDR_W-1:0] pcN, target;
  logic [TSET_W-1:0] tsetReg;
  logic              errN;
  logic              sClr, sPush, sPop, sDec;
  logic [ADDR_W-1:0] topStart;
  logic [OPND_W-1:0] topCnt;
  logic              stEmpty, stFull;

  assign opc    = seqOp_e'(curOp);
  assign target = curOpnd[ADDR_W-1:0];

  vec_seq_lstack #(
    .DEPTH (LOOP_DEPTH),
    .ADDR_W(ADDR_W),
    .CNT_W (OPND_W)
  ) u_stack (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (sClr),
    .push     (sPush),
    .pop      (sPop),
    .dec      (sDec),
    .pushStart(pc + 1'b1),
    .pushCnt  (curOpnd),
    .topStart (topStart),
    .topCnt   (topCnt),
    .empty    (stEmpty),
    .full     (stFull)
  );

  always_comb begin
    stateN   = state;
    pcN      = pc;
    tsetNext = tsetReg;
    errN     = overflowErr;
    stb      = '0;
    sClr     = 1'b0;
    sPush    = 1'b0;
    sPop     = 1'b0;
    sDec     = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stateN   = ST_RUN;
          pcN      = '0;
          tsetNext = '0;
          errN     = 1'b0;
          sClr     = 1'b1;
        end
      end
      ST_RUN: begin
        pcN       = pc + 1'b1;
        stb.issue = 1'b1;
        unique case (opc)
          OP_TSET: tsetNext = curTset;
          OP_LOOP: begin
            if (stFull) begin
              stb.issue = 1'b0;
              stb.stop  = 1'b1;
              errN      = 1'b1;
              stateN    = ST_DONE;
              pcN       = pc;
            end else begin
              sPush = 1'b1;
            end
          end
          OP_ENDL: begin
            if (!stEmpty) begin
              if (topCnt == '0) begin
                pcN = topStart;
              end else if (topCnt == OPND_W'(1)) begin
                sPop = 1'b1;
              end else begin
                sDec = 1'b1;
                pcN  = topStart;
              end
            end
          end
          OP_JPAR, OP_JSER: begin
            if ((opc == OP_JPAR) ? parHit : serHit) begin
              pcN  = target;
              sPop = !stEmpty;
            end
          end
          OP_WAIT: stateN = ST_WAIT;
          OP_HALT: begin
            stb.issue = 1'b0;
            stb.stop  = 1'b1;
            stateN    = ST_DONE;
            pcN       = pc;
          end
          default: ;
        endcase
      end
      ST_WAIT: begin
        if (swTrig) begin
          stateN = ST_RUN;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      pc          <= '0;
      tsetReg     <= '0;
      overflowErr <= 1'b0;
    end else begin
      state       <= stateN;
      pc          <= pcN;
      tsetReg     <= tsetNext;
      overflowErr <= errN;
    end
  end

  assign waiting = (state == ST_WAIT);
  assign halted  = (state == ST_DONE);

endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vec_seq_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int TSET_W     = 2,
  parameter int OPND_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int SER_W      = 8,
  parameter int LOOP_DEPTH = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic                                swTrig,
  input  logic                                hostWe,
  input  logic                                hostVecOnly,
  input  logic [ADDR_W-1:0]                   hostAddr,
  input  logic [OP_W+OPND_W+TSET_W+VEC_W-1:0] hostData,
  input  logic [VEC_W-1:0]                    capData,
  input  logic                                capBit,
  input  logic                                capValid,
  input  logic [VEC_W-1:0]                    parPat,
  input  logic [VEC_W-1:0]                    parMask,
  input  logic [SER_W-1:0]                    serPat,
  input  logic [SER_W-1:0]                    serMask,
  output logic [VEC_W-1:0]                    vecOut,
  output logic [TSET_W-1:0]                   tsetOut,
  output logic                                vecValid,
  output logic                                waiting,
  output logic                                halted,
  output logic                                overflowErr
);

  logic [ADDR_W-1:0] pc;
  seqStrobe_t        stb;
  logic [TSET_W-1:0] tsetNext;
  logic [OP_W-1:0]   curOp;
  logic [OPND_W-1:0] curOpnd;
  logic [TSET_W-1:0] curTset;
  logic              parHit, serHit;

  vec_seq_ctrl #(
    .TSET_W    (TSET_W),
    .OPND_W    (OPND_W),
    .ADDR_W    (ADDR_W),
    .LOOP_DEPTH(LOOP_DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .swTrig     (swTrig),
    .curOp      (curOp),
    .curOpnd    (curOpnd),
    .curTset    (curTset),
    .parHit     (parHit),
    .serHit     (serHit),
    .pc         (pc),
    .stb        (stb),
    .tsetNext   (tsetNext),
    .waiting    (waiting),
    .halted     (halted),
    .overflowErr(overflowErr)
  );

  vec_seq_dp #(
    .VEC_W (VEC_W),
    .TSET_W(TSET_W),
    .OPND_W(OPND_W),
    .ADDR_W(ADDR_W),
    .SER_W (SER_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pc         (pc),
    .stb        (stb),
    .tsetIn     (tsetNext),
    .hostWe     (hostWe),
    .hostVecOnly(hostVecOnly),
    .hostAddr   (hostAddr),
    .hostData   (hostData),
    .capData    (capData),
    .capBit     (capBit),
    .capValid   (capValid),
    .parPat     (parPat),
    .parMask    (parMask),
    .serPat     (serPat),
    .serMask    (serMask),
    .curOp      (curOp),
    .curOpnd    (curOpnd),
    .curTset    (curTset),
    .parHit     (parHit),
    .serHit     (serHit),
    .vecOut     (vecOut),
    .tsetOut    (tsetOut),
    .vecValid   (vecValid)
  );

endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             swTrig,
  input logic [VEC_W-1:0] vecOut,
  input logic             vecValid,
  input logic             waiting,
  input logic             halted,
  input logic             overflowErr
);

  a_r10_hold_vector: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !swTrig) |=> (waiting && vecValid && $stable(vecOut)));

  a_r10_wait_has_vector: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> vecValid);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !vecValid);

  a_r7_overflow_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowErr) |-> halted);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !start) |=> overflowErr);

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    (halted && start) |=> (!halted && !overflowErr));

endmodule

bind vec_seq vec_seq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .swTrig     (swTrig),
  .vecOut     (vecOut),
  .vecValid   (vecValid),
  .waiting    (waiting),
  .halted     (halted),
  .overflowErr(overflowErr)
);

// File: tb/vec_seq_bench.sv
`timescale 1ns/1ps
module vec_seq_bench;

  localparam int MEMD = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, swTrig = 1'b0;
  logic        hostWe = 1'b0, hostVecOnly = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [20:0] hostData = '0;
  logic [7:0]  capData = '0;
  logic        capBit = 1'b0, capValid = 1'b0;
  logic [7:0]  parPat = '0, parMask = '0, serPat = '0, serMask = '0;
  logic [7:0]  vecOut;
  logic [1:0]  tsetOut;
  logic        vecValid, waiting, halted, overflowErr;

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R13";
  int seen [256];
  int tsetSeen [256];

  // behavioural reference state
  int mState = 0;  // 0 idle, 1 run, 2 wait, 3 stopped
  int mPc = 0, mTset = 0, mErr = 0, mShr = 0;
  int expVec = 0, expTset = 0, expValid = 0;
  int stS[$];
  int stC[$];
  int mm [MEMD];

  always #2 clk = ~clk;

  vec_seq u_vec_seq (
    .clk(clk), .rstN(rstN), .start(start), .swTrig(swTrig),
    .hostWe(hostWe), .hostVecOnly(hostVecOnly), .hostAddr(hostAddr), .hostData(hostData),
    .capData(capData), .capBit(capBit), .capValid(capValid),
    .parPat(parPat), .parMask(parMask), .serPat(serPat), .serMask(serMask),
    .vecOut(vecOut), .tsetOut(tsetOut), .vecValid(vecValid),
    .waiting(waiting), .halted(halted), .overflowErr(overflowErr)
  );

  function automatic int mkWord(int op, int opnd, int ts, int v);
    return (op << 18) | (opnd << 10) | (ts << 8) | v;
  endfunction

  always @(posedge clk) begin : m_step
    int w, op, opnd, tf, vv, nxt, top;
    bit ph, sh, iss, stp;
    if (!rstN) begin
      mState = 0; mPc = 0; mTset = 0; mErr = 0; mShr = 0;
      expVec = 0; expTset = 0; expValid = 0;
      stS.delete(); stC.delete();
    end else begin
      w = mm[mPc];
      op = (w >> 18) & 7; opnd = (w >> 10) & 255; tf = (w >> 8) & 3; vv = w & 255;
      ph = (((int'(capData) ^ int'(parPat)) & int'(parMask)) == 0);
      sh = (((mShr ^ int'(serPat)) & int'(serMask)) == 0);
      iss = 0; stp = 0;
      case (mState)
        0, 3: if (start) begin
          mState = 1; mPc = 0; mTset = 0; mErr = 0; stS.delete(); stC.delete();
        end
        1: begin
          iss = 1; nxt = (mPc + 1) % MEMD;
          case (op)
            1: mTset = tf;
            2: if (stS.size() == 4) begin
                 iss = 0; stp = 1; mErr = 1; mState = 3; nxt = mPc;
               end else begin
                 stS.push_back((mPc + 1) % MEMD); stC.push_back(opnd);
               end
            3: if (stS.size() > 0) begin
                 top = stC[stC.size()-1];
                 if (top == 0) nxt = stS[stS.size()-1];
                 else if (top == 1) begin void'(stS.pop_back()); void'(stC.pop_back()); end
                 else begin stC[stC.size()-1] = top - 1; nxt = stS[stS.size()-1]; end
               end
            4, 5: if ((op == 4) ? ph : sh) begin
                 nxt = opnd % MEMD;
                 if (stS.size() > 0) begin void'(stS.pop_back()); void'(stC.pop_back()); end
               end
            6: mState = 2;
            7: begin iss = 0; stp = 1; mState = 3; nxt = mPc; end
            default: ;
          endcase
          if (iss) begin expVec = vv; expTset = mTset; expValid = 1; end
          if (stp) expValid = 0;
          mPc = nxt;
        end
        2: if (swTrig) mState = 1;
        default: ;
      endcase
      if (hostWe) begin
        if (hostVecOnly) mm[hostAddr] = (mm[hostAddr] & ~255) | int'(hostData[7:0]);
        else mm[hostAddr] = int'(hostData);
      end
      if (capValid) mShr = ((mShr << 1) | int'(capBit)) & 255;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      chk(int'(vecValid) == expValid, {"R3/", curReq}, "vecValid", int'(vecValid), expValid);
      if (expValid != 0) begin
        chk(int'(vecOut) == expVec, {"R3/", curReq}, "vecOut", int'(vecOut), expVec);
        chk(int'(tsetOut) == expTset, {"R4/", curReq}, "tsetOut", int'(tsetOut), expTset);
      end
      chk(waiting == (mState == 2), {"R10/", curReq}, "waiting", int'(waiting), int'(mState == 2));
      chk(halted == (mState == 3), {"R11/", curReq}, "halted", int'(halted), int'(mState == 3));
      chk(int'(overflowErr) == mErr, {"R7/", curReq}, "overflowErr", int'(overflowErr), mErr);
      if (vecValid) begin
        seen[vecOut]++;
        tsetSeen[vecOut] = int'(tsetOut);
      end
    end
  endtask

  task automatic clearSeen();
    for (int i = 0; i < 256; i++) begin seen[i] = 0; tsetSeen[i] = 0; end
  endtask

  task automatic wr(int addr, int word, bit vecOnly);
    hostWe = 1'b1; hostVecOnly = vecOnly; hostAddr = 5'(addr); hostData = 21'(word);
    tick();
    hostWe = 1'b0; hostVecOnly = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic runToHalt(int limit);
    for (int i = 0; i < limit; i++) begin
      tick();
      if (halted) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMD; i++) mm[i] = 0;
    clearSeen();
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(vecOut == 0 && tsetOut == 0, "R13", "vec/tset", int'(vecOut), 0);
    chk(!vecValid && !waiting, "R13", "valid/wait", int'(vecValid), 0);
    chk(!halted && !overflowErr, "R13", "halt/err", int'(halted), 0);
    rstN = 1'b1;

    // R1 R2 R4 R5: timing set and counted loop
    curReq = "R5";
    wr(0, mkWord(1, 0, 2, 8'h11), 0);
    wr(1, mkWord(2, 3, 0, 8'h20), 0);
    wr(2, mkWord(0, 0, 0, 8'h21), 0);
    wr(3, mkWord(3, 0, 0, 8'h22), 0);
    wr(4, mkWord(0, 0, 1, 8'h23), 0);
    wr(5, mkWord(7, 0, 0, 8'h00), 0);
    clearSeen();
    pulseStart();
    chk(!vecValid, "R2", "valid one cycle after start", int'(vecValid), 0);
    tick();
    chk(vecValid && vecOut == 8'h11, "R2", "first vector", int'(vecOut), 'h11);
    chk(tsetOut == 2, "R4", "timing set on its own vector", int'(tsetOut), 2);
    runToHalt(40);
    chk(seen['h21] == 3, "R5", "loop body passes", seen['h21], 3);
    chk(tsetSeen['h23] == 2, "R4", "field ignored by no-op", tsetSeen['h23], 2);
    chk(halted && !vecValid, "R11", "stopped", int'(halted), 1);

    // R7: four nested loops, then overflow
    curReq = "R7";
    for (int i = 0; i < 4; i++) wr(i, mkWord(2, 2, 0, 8'h30 + i), 0);
    wr(4, mkWord(0, 0, 0, 8'h40), 0);
    for (int i = 5; i < 9; i++) wr(i, mkWord(3, 0, 0, 8'h45), 0);
    wr(9, mkWord(7, 0, 0, 0), 0);
    clearSeen();
    pulseStart();
    runToHalt(200);
    chk(seen['h40] == 16, "R7", "depth-4 nest body", seen['h40], 16);
    chk(!overflowErr, "R7", "no error at depth 4", int'(overflowErr), 0);
    wr(4, mkWord(2, 1, 0, 8'h34), 0);
    wr(5, mkWord(7, 0, 0, 0), 0);
    clearSeen();
    pulseStart();
    runToHalt(40);
    chk(overflowErr && halted, "R7", "fifth level overflow", int'(overflowErr), 1);
    chk(seen['h34] == 0, "R7", "overflow word not issued", seen['h34], 0);
    pulseStart();
    chk(!overflowErr && !halted, "R2", "restart clears error", int'(overflowErr), 0);
    runToHalt(40);

    // R6 R8 R12: endless loop, live patch, parallel jump
    curReq = "R8";
    parPat = 8'hA5; parMask = 8'hF0; capData = 8'h00;
    wr(0, mkWord(2, 0, 0, 8'h50), 0);
    wr(1, mkWord(0, 0, 0, 8'h51), 0);
    wr(2, mkWord(4, 6, 0, 8'h52), 0);
    wr(3, mkWord(3, 0, 0, 8'h53), 0);
    wr(4, mkWord(0, 0, 0, 8'h54), 0);
    wr(6, mkWord(0, 0, 0, 8'h56), 0);
    wr(7, mkWord(3, 0, 0, 8'h57), 0);
    wr(8, mkWord(7, 0, 0, 0), 0);
    clearSeen();
    pulseStart();
    repeat (20) tick();
    chk(!halted && vecValid, "R6", "endless loop keeps running", int'(halted), 0);
    curReq = "R12";
    wr(1, 8'h5E, 1);
    repeat (12) tick();
    chk(seen['h5E] > 0, "R12", "patched vector issued", seen['h5E], 1);
    chk(!halted, "R12", "opcode kept by patch", int'(halted), 0);
    curReq = "R2";
    pulseStart();
    repeat (4) tick();
    chk(!halted && vecValid, "R2", "start ignored while running", int'(vecValid), 1);
    curReq = "R8";
    capData = 8'hAF;
    runToHalt(40);
    capData = 8'h00;
    chk(halted, "R8", "masked match jumps out", int'(halted), 1);
    chk(seen['h54] == 0 && seen['h56] == 1, "R8", "jump target", seen['h56], 1);
    chk(seen['h57] == 1, "R6", "close with no loop is no-op", seen['h57], 1);

    // R9: serial match
    curReq = "R9";
    serPat = 8'h0B; serMask = 8'h0F;
    wr(0, mkWord(2, 0, 0, 8'h60), 0);
    wr(1, mkWord(5, 3, 0, 8'h61), 0);
    wr(2, mkWord(3, 0, 0, 8'h62), 0);
    wr(3, mkWord(7, 0, 0, 0), 0);
    pulseStart();
    repeat (5) tick();
    foreach (stS[i]) ;
    for (int b = 0; b < 3; b++) begin
      capBit = (b != 1); capValid = 1'b1; tick();
      capValid = 1'b0; capBit = 1'b1; tick(); tick();
    end
    chk(!halted, "R9", "partial serial pattern", int'(halted), 0);
    capBit = 1'b1; capValid = 1'b1; tick();
    capValid = 1'b0; capBit = 1'b0;
    runToHalt(10);
    chk(halted, "R9", "serial match jumps", int'(halted), 1);

    // R10: trigger wait
    curReq = "R10";
    wr(0, mkWord(0, 0, 0, 8'h70), 0);
    wr(1, mkWord(6, 0, 0, 8'h71), 0);
    wr(2, mkWord(0, 0, 0, 8'h72), 0);
    wr(3, mkWord(7, 0, 0, 0), 0);
    clearSeen();
    pulseStart();
    for (int i = 0; i < 10; i++) begin
      tick();
      if (waiting) break;
    end
    repeat (8) tick();
    chk(waiting && vecValid && vecOut == 8'h71, "R10", "held vector", int'(vecOut), 'h71);
    swTrig = 1'b1; tick(); swTrig = 1'b0;
    runToHalt(10);
    chk(seen['h72] == 1 && halted, "R10", "trigger advances", seen['h72], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule